// File: doc/BRIEF.md
# Round Key Generator with Nibble Interleave

This block expands a 64-bit cipher key into five 16-bit round keys for a five-round lightweight block cipher. The key is cut into sixteen 4-bit nibbles, which are gathered with a stride of four into four 16-bit words. Each word passes through a small substitution network: a layer of 4-bit lookups, a fixed bit shuffle, and a second layer of 4-bit lookups. The four results are registered as the first four round keys. The fifth key is the XOR of those four.

The cipher datapath asserts a one-cycle load strobe along with a key. On the next clock the five round keys are present, and a valid flag rises and stays high. The keys stay unchanged until another load, and changes on the key input in between have no effect. The valid flag drops only on reset.

Top module: `rkey_expander`

## Requirements
- R1: Nibbles are numbered 1 to 16, with nibble 1 at key bits 63:60 and nibble 16 at bits 3:0. Word w (w = 1..4) is formed from nibbles w, w+4, w+8 and w+12, with the first of these in bits 15:12.
- R2: The substitution first maps the four nibbles of a word, from most to least significant, through tables A, B, A, B. After the shuffle it maps them through B, A, B, A. Table A sends 0..F to 3,F,E,0,5,4,B,C,D,A,9,6,7,8,2,1. Table B sends 0..F to 9,E,5,6,A,2,3,C,F,0,4,D,7,B,1,8.
- R3: Between the two table layers, the bit pairs are reordered. Number the bits 0 to 15 from the MSB. Taken as pairs, the output pairs 0..7 come from the input pairs 0,2,1,4,3,6,5,7.
- R4: Round keys 1 to 4 are the substitution results of words 1 to 4, in that order, each held in its own register.
- R5: Round key 5 equals round key 1 XOR round key 2 XOR round key 3 XOR round key 4.
- R6: When the load strobe is high at a rising clock edge, the key is captured. The keys and the valid flag show the result right after that edge. Valid then stays high.
- R7: Without a load, all round keys hold their values and changes of the key input have no effect.
- R8: An active-low reset clears all round keys to zero and deasserts valid, whatever the other inputs are doing.
- R9: A load while keys are already valid replaces all five keys one clock later, including loads on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | 64 | Cipher key |
| load_i | input | 1 | Capture strobe for key_i |
| rk1_o | output | 16 | Round key 1 |
| rk2_o | output | 16 | Round key 2 |
| rk3_o | output | 16 | Round key 3 |
| rk4_o | output | 16 | Round key 4 |
| rk5_o | output | 16 | Round key 5 (XOR of keys 1-4) |
| keys_valid_o | output | 1 | Round keys hold a loaded result |

## Verification
The expansion is tried with several key types, and each type separates a different kind of fault:
- All-zero and all-one keys check the table entries at the ends of the range.
- A repeated-nibble key makes all four words equal, so round key 5 must come out as zero.
- An ascending-nibble key gives four distinct words. Any mix-up in the word order or the key order shows up here.
- A key with a single set nibble, walked through all sixteen positions, confirms which word and which slot each nibble lands in.

Separate runs change the key input without a load, issue back-to-back loads, and apply reset in the middle of operation. These runs separate the hold, replace and clear behaviour.

// File: rtl/rkx_pkg.sv
package rkx_pkg;

   localparam int NIB_BITS = 4;

   // first table of the mini substitution
   function automatic logic [3:0] tab_a(input logic [3:0] x);
      logic [3:0] r;
      case (x)
         4'h0: r = 4'h3;  4'h1: r = 4'hF;  4'h2: r = 4'hE;  4'h3: r = 4'h0;
         4'h4: r = 4'h5;  4'h5: r = 4'h4;  4'h6: r = 4'hB;  4'h7: r = 4'hC;
         4'h8: r = 4'hD;  4'h9: r = 4'hA;  4'hA: r = 4'h9;  4'hB: r = 4'h6;
         4'hC: r = 4'h7;  4'hD: r = 4'h8;  4'hE: r = 4'h2;  default: r = 4'h1;
      endcase
      return r;
   endfunction

   // second table of the mini substitution
   function automatic logic [3:0] tab_b(input logic [3:0] x);
      logic [3:0] r;
      case (x)
         4'h0: r = 4'h9;  4'h1: r = 4'hE;  4'h2: r = 4'h5;  4'h3: r = 4'h6;
         4'h4: r = 4'hA;  4'h5: r = 4'h2;  4'h6: r = 4'h3;  4'h7: r = 4'hC;
         4'h8: r = 4'hF;  4'h9: r = 4'h0;  4'hA: r = 4'h4;  4'hB: r = 4'hD;
         4'hC: r = 4'h7;  4'hD: r = 4'hB;  4'hE: r = 4'h1;  default: r = 4'h8;
      endcase
      return r;
   endfunction

   // source pair for output pair p (pairs counted from the MSB)
   function automatic int pair_src(input int p, input int npairs);
      int r;
      if (p == 0 || p == npairs - 1) r = p;
      else if (p % 2 == 1)           r = p + 1;
      else                           r = p - 1;
      return r;
   endfunction

endpackage

// File: rtl/rkx_regroup.sv
module rkx_regroup #(
   parameter int KEY_W  = 64,
   parameter int NIB_W  = 4,
   parameter int N_WORD = 4,
   localparam int WORD_W = KEY_W / N_WORD,
   localparam int N_NIB  = KEY_W / NIB_W,
   localparam int PER_W  = WORD_W / NIB_W
) (
   input  logic [KEY_W-1:0]              key_i,
   output logic [N_WORD-1:0][WORD_W-1:0] words_o
);

   if (N_NIB != N_WORD * PER_W) begin : g_bad_split
      $error("rkx_regroup: key does not split evenly into words");
   end

   // word w (0-based) takes nibbles w+1, w+1+N_WORD, ... (1-based, nibble 1 at MSB)
   for (genvar w = 0; w < N_WORD; w++) begin : g_word
      for (genvar j = 0; j < PER_W; j++) begin : g_slot
         localparam int NIB_NUM = w + 1 + N_WORD * j;
         localparam int KEY_HI  = KEY_W - 1 - NIB_W * (NIB_NUM - 1);
         localparam int WRD_HI  = WORD_W - 1 - NIB_W * j;
         assign words_o[w][WRD_HI -: NIB_W] = key_i[KEY_HI -: NIB_W];
      end
   end

endmodule

// File: rtl/rkx_subst16.sv
module rkx_subst16 #(
   parameter int WORD_W = 16,
   parameter int NIB_W  = 4,
   localparam int N_NIB   = WORD_W / NIB_W,
   localparam int N_PAIRS = WORD_W / 2
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   import rkx_pkg::*;

   if (NIB_W != NIB_BITS || WORD_W != 16) begin : g_bad_width
      $error("rkx_subst16: only 4-bit nibbles in a 16-bit word are supported");
   end

   logic [WORD_W-1:0] lay1;
   logic [WORD_W-1:0] mixed;

   // first layer: A,B,A,B from the most significant nibble
   for (genvar j = 0; j < N_NIB; j++) begin : g_lay1
      localparam int HI = WORD_W - 1 - NIB_W * j;
      if (j % 2 == 0) begin : g_a
         assign lay1[HI -: NIB_W] = tab_a(din[HI -: NIB_W]);
      end else begin : g_b
         assign lay1[HI -: NIB_W] = tab_b(din[HI -: NIB_W]);
      end
   end

   // pair shuffle between layers
   for (genvar p = 0; p < N_PAIRS; p++) begin : g_mix
      localparam int SRC = pair_src(p, N_PAIRS);
      assign mixed[WORD_W - 1 - 2*p -: 2] = lay1[WORD_W - 1 - 2*SRC -: 2];
   end

   // second layer: B,A,B,A from the most significant nibble
   for (genvar j = 0; j < N_NIB; j++) begin : g_lay2
      localparam int HI = WORD_W - 1 - NIB_W * j;
      if (j % 2 == 0) begin : g_b
         assign dout[HI -: NIB_W] = tab_b(mixed[HI -: NIB_W]);
      end else begin : g_a
         assign dout[HI -: NIB_W] = tab_a(mixed[HI -: NIB_W]);
      end
   end

endmodule

// File: rtl/rkx_fold.sv
module rkx_fold #(
   parameter int WORD_W = 16,
   parameter int N_IN   = 4
) (
   input  logic [N_IN-1:0][WORD_W-1:0] vals_i,
   output logic [WORD_W-1:0]           fold_o
);

   if (N_IN < 2) begin : g_bad_count
      $error("rkx_fold: needs at least two inputs");
   end

   always_comb begin
      fold_o = '0;
      for (int i = 0; i < N_IN; i++) begin
         fold_o = fold_o ^ vals_i[i];
      end
   end

endmodule

// File: rtl/rkey_expander.sv
module rkey_expander #(
   parameter int KEY_W  = 64,
   parameter int NIB_W  = 4,
   parameter int N_WORD = 4,
   localparam int WORD_W = KEY_W / N_WORD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KEY_W-1:0]  key_i,
   input  logic              load_i,
   output logic [WORD_W-1:0] rk1_o,
   output logic [WORD_W-1:0] rk2_o,
   output logic [WORD_W-1:0] rk3_o,
   output logic [WORD_W-1:0] rk4_o,
   output logic [WORD_W-1:0] rk5_o,
   output logic              keys_valid_o
);

   if (N_WORD != 4 || KEY_W != N_WORD * WORD_W) begin : g_bad_cfg
      $error("rkey_expander: four words per key are required");
   end

   logic [N_WORD-1:0][WORD_W-1:0] words_w;
   logic [N_WORD-1:0][WORD_W-1:0] sub_w;
   logic [N_WORD-1:0][WORD_W-1:0] rk_q;
   logic                          valid_q;

   rkx_regroup #(.KEY_W(KEY_W), .NIB_W(NIB_W), .N_WORD(N_WORD)) u_regroup (
      .key_i   (key_i),
      .words_o (words_w)
   );

   for (genvar w = 0; w < N_WORD; w++) begin : g_round
      rkx_subst16 #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_sub (
         .din  (words_w[w]),
         .dout (sub_w[w])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rk_q[w] <= '0;
         else if (load_i) rk_q[w] <= sub_w[w];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      valid_q <= 1'b0;
      else if (load_i) valid_q <= 1'b1;
   end

   rkx_fold #(.WORD_W(WORD_W), .N_IN(N_WORD)) u_fold (
      .vals_i (rk_q),
      .fold_o (rk5_o)
   );

   assign rk1_o        = rk_q[0];
   assign rk2_o        = rk_q[1];
   assign rk3_o        = rk_q[2];
   assign rk4_o        = rk_q[3];
   assign keys_valid_o = valid_q;

   // R6
   load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> keys_valid_o);

   // R6
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      keys_valid_o |=> keys_valid_o);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(rk1_o) && $stable(rk2_o) && $stable(rk3_o) && $stable(rk4_o)));

   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !keys_valid_o |-> ((rk1_o | rk2_o | rk3_o | rk4_o | rk5_o) == '0));

   // R1
   regroup_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(key_i) == $countones(words_w));

endmodule

// File: tb/rkey_expander_bench.sv
module rkey_expander_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] key_i = '0;
   logic        load_i = 1'b0;
   logic [15:0] rk1_o, rk2_o, rk3_o, rk4_o, rk5_o;
   logic        keys_valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam int TA[16] = '{3,15,14,0,5,4,11,12,13,10,9,6,7,8,2,1};
   localparam int TB[16] = '{9,14,5,6,10,2,3,12,15,0,4,13,7,11,1,8};
   localparam int PAIR_FROM[8] = '{0,2,1,4,3,6,5,7};

   rkey_expander u_rkey_expander (
      .clk(clk), .rst_n(rst_n), .key_i(key_i), .load_i(load_i),
      .rk1_o(rk1_o), .rk2_o(rk2_o), .rk3_o(rk3_o), .rk4_o(rk4_o), .rk5_o(rk5_o),
      .keys_valid_o(keys_valid_o)
   );

   always #4 clk = ~clk;

   // reference model helpers (integer arithmetic, MSB-first numbering)
   function automatic int nib_of(input logic [63:0] k, input int n);
      return int'((k >> (64 - 4*n)) & 64'hF);
   endfunction

   function automatic int sub_ref(input int w);
      int n[4];
      int b[16];
      int m[16];
      int r;
      for (int j = 0; j < 4; j++) begin
         n[j] = (w >> (12 - 4*j)) & 15;
         n[j] = (j % 2 == 0) ? TA[n[j]] : TB[n[j]];
      end
      for (int k = 0; k < 16; k++) b[k] = (n[k/4] >> (3 - k%4)) & 1;
      for (int k = 0; k < 16; k++) m[k] = b[2*PAIR_FROM[k/2] + k%2];
      r = 0;
      for (int j = 0; j < 4; j++) begin
         int v = m[4*j]*8 + m[4*j+1]*4 + m[4*j+2]*2 + m[4*j+3];
         v = (j % 2 == 0) ? TB[v] : TA[v];
         r = r | (v << (12 - 4*j));
      end
      return r;
   endfunction

   function automatic int rk_ref(input logic [63:0] k, input int idx);
      int w = 0;
      for (int j = 0; j < 4; j++) w = w | (nib_of(k, idx + 4*j) << (12 - 4*j));
      return sub_ref(w);
   endfunction

   // cycle model
   logic [15:0] exp_rk[5];
   logic        exp_valid;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 5; i++) exp_rk[i] <= '0;
         exp_valid <= 1'b0;
      end else if (load_i) begin
         logic [15:0] x;
         x = '0;
         for (int i = 0; i < 4; i++) begin
            exp_rk[i] <= 16'(rk_ref(key_i, i + 1));
            x = x ^ 16'(rk_ref(key_i, i + 1));
         end
         exp_rk[4] <= x;
         exp_valid <= 1'b1;
      end
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         check("R4 rk1", rk1_o, exp_rk[0]);
         check("R4 rk2", rk2_o, exp_rk[1]);
         check("R4 rk3", rk3_o, exp_rk[2]);
         check("R4 rk4", rk4_o, exp_rk[3]);
         check("R5 rk5", rk5_o, exp_rk[4]);
         check("R6 valid", {15'd0, keys_valid_o}, {15'd0, exp_valid});
      end
   end

   task automatic load_key(input logic [63:0] k);
      @(negedge clk);
      key_i  = k;
      load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] saved;
      // R8 reset state, with load driven during reset
      load_i = 1'b1;
      key_i  = 64'hFFFF_FFFF_FFFF_FFFF;
      repeat (3) @(negedge clk);
      check("R8 reset rk1", rk1_o, 16'h0);
      check("R8 reset rk5", rk5_o, 16'h0);
      check("R8 reset valid", {15'd0, keys_valid_o}, 16'h0);
      load_i = 1'b0;
      rst_n  = 1'b1;
      @(negedge clk);

      // R2 table extremes
      load_key(64'h0);
      check("R2 zero key rk1", rk1_o, 16'(rk_ref(64'h0, 1)));
      load_key(64'hFFFF_FFFF_FFFF_FFFF);
      check("R2 ones key rk2", rk2_o, 16'(rk_ref(64'hFFFF_FFFF_FFFF_FFFF, 2)));
      // R5 equal words fold to zero
      load_key(64'hAAAA_AAAA_AAAA_AAAA);
      check("R5 equal words", rk5_o, 16'h0);
      // R3 R4 distinct words
      load_key(64'h0123_4567_89AB_CDEF);
      check("R3 ascending rk3", rk3_o, 16'(rk_ref(64'h0123_4567_89AB_CDEF, 3)));
      check("R4 ascending rk4", rk4_o, 16'(rk_ref(64'h0123_4567_89AB_CDEF, 4)));

      // R1 walking nibble
      for (int n = 1; n <= 16; n++) begin
         logic [63:0] k = 64'h9 << (64 - 4*n);
         load_key(k);
         case ((n - 1) % 4)
            0: check("R1 walk word1", rk1_o, 16'(rk_ref(k, 1)));
            1: check("R1 walk word2", rk2_o, 16'(rk_ref(k, 2)));
            2: check("R1 walk word3", rk3_o, 16'(rk_ref(k, 3)));
            default: check("R1 walk word4", rk4_o, 16'(rk_ref(k, 4)));
         endcase
      end

      // R7 key changes without load are ignored
      load_key(64'h1357_9BDF_0246_8ACE);
      saved = rk1_o;
      key_i = 64'hDEAD_BEEF_0BAD_F00D;
      repeat (4) @(negedge clk);
      check("R7 ignored key change", rk1_o, saved);
      check("R7 valid held", {15'd0, keys_valid_o}, 16'h1);

      // R9 back-to-back loads
      @(negedge clk);
      key_i = 64'h1111_2222_3333_4444; load_i = 1'b1;
      @(negedge clk);
      check("R9 first of pair", rk2_o, 16'(rk_ref(64'h1111_2222_3333_4444, 2)));
      key_i = 64'h5555_6666_7777_8888;
      @(negedge clk);
      load_i = 1'b0;
      check("R9 second of pair", rk2_o, 16'(rk_ref(64'h5555_6666_7777_8888, 2)));

      // R8 mid-run reset
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 midrun rk4", rk4_o, 16'h0);
      check("R8 midrun valid", {15'd0, keys_valid_o}, 16'h0);
      rst_n = 1'b1;
      load_key(64'hFEDC_BA98_7654_3210);
      repeat (2) @(negedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule